// File: doc/BRIEF.md
# Four-Slot Asymmetric Instruction Steering

This block sits between a queue of pre-decoded, length-marked instructions and a row of four decoders. Slot 0 is a full decoder that accepts any instruction. Slots 1 to 3 are narrow decoders that accept only simple instructions. Each cycle the block looks at the oldest entries of the queue and picks the longest run of them that can be decoded together. It places entry j of that run in slot j.

Four things end the run: an invalid entry, an instruction that is too complex for a narrow slot, a change of 16-byte fetch window, and a predicted-taken branch. The branch itself is still included in the run. The number of entries consumed goes back to the queue straight away, so the queue can advance its read pointer in the same cycle. The slot outputs are registered and carry a program-order sequence number, which lets the order of the instructions be checked downstream.

Top module: `dsteer_top`

## Requirements
- R1: While reset is held and after it is released, every slot valid bit is 0 and the sequence counter starts at 0.
- R2: When out_ready is 1 and entry 0 is valid, entry 0 is consumed into slot 0 whatever its micro-op count.
- R3: An entry at position j>0 whose micro-op count is above SIMPLE_MAX (default 2, so a count of 3 is complex and 2 is simple) is not consumed. No entry after it is consumed that cycle.
- R4: An entry at position j>0 whose window tag differs from entry 0's tag is not consumed. No entry after it is consumed that cycle.
- R5: A consumed entry with in_taken set is the last entry consumed that cycle.
- R6: An invalid entry stops the run. Consumption is a contiguous prefix of the entries.
- R7: When out_ready is 0, consume_cnt is 0. At the next edge, slot_valid and slot_seq keep their values.
- R8: When out_ready is 1, consume_cnt is combinational from the inputs. After the edge, slot_valid has its lowest consume_cnt bits set and no others.
- R9: Slot j's sequence number, in field j of slot_seq (SEQW bits each, slot 0 in the lowest bits), equals the count of all entries consumed earlier plus j, modulo 2^SEQW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NSLOT | Valid bit per head entry, bit j = entry j |
| in_uops | input | NSLOT*UOPW | Fused micro-op count per entry, field j = entry j |
| in_win | input | NSLOT*WINW | Fetch-window tag per entry |
| in_taken | input | NSLOT | Predicted-taken-branch flag per entry |
| out_ready | input | 1 | Downstream can accept a new group |
| consume_cnt | output | $clog2(NSLOT+1) | Entries consumed this cycle |
| slot_valid | output | NSLOT | Registered per-slot valid |
| slot_seq | output | NSLOT*SEQW | Registered per-slot sequence number |

## Verification
The assertions assume the queue presents entries in program order and head-aligned, and that out_ready stays stable between clock edges. The bench drives new inputs only at the falling edge and holds them through the rising edge, so both conditions always hold. It sweeps every combination of valid, complexity, window change and taken flag across all four entries. It inserts stall cycles regularly and checks the counts and sequence numbers against an arithmetic model of the run length.

// File: rtl/dsteer_pkg.sv
package dsteer_pkg;
   typedef enum logic [2:0] {
      CUT_NONE    = 3'd0,
      CUT_INVALID = 3'd1,
      CUT_COMPLEX = 3'd2,
      CUT_WINDOW  = 3'd3
   } cut_e;

   function automatic logic cut_blocks(input cut_e c);
      return c != CUT_NONE;
   endfunction
endpackage

// File: rtl/dsteer_class.sv
module dsteer_class
   import dsteer_pkg::*;
#(
   parameter int UOPW       = 3,
   parameter int WINW       = 4,
   parameter int SIMPLE_MAX = 2,
   parameter bit IS_HEAD    = 1'b0
) (
   input  logic            valid,
   input  logic [UOPW-1:0] uops,
   input  logic [WINW-1:0] win,
   input  logic [WINW-1:0] head_win,
   input  logic            taken,
   output logic            blocked,
   output logic            ends_run
);
   cut_e cut;

   generate
      if (IS_HEAD) begin : g_head
         // full decoder: only validity matters
         always_comb cut = valid ? CUT_NONE : CUT_INVALID;
      end else begin : g_narrow
         always_comb begin
            if (!valid)                       cut = CUT_INVALID;
            else if (uops > UOPW'(SIMPLE_MAX)) cut = CUT_COMPLEX;
            else if (win != head_win)         cut = CUT_WINDOW;
            else                              cut = CUT_NONE;
         end
      end
   endgenerate

   assign blocked  = cut_blocks(cut);
   assign ends_run = taken;
endmodule

// File: rtl/dsteer_chain.sv
module dsteer_chain #(
   parameter int NSLOT = 4,
   localparam int CNTW = $clog2(NSLOT + 1)
) (
   input  logic [NSLOT-1:0] blocked,
   input  logic [NSLOT-1:0] ends_run,
   output logic [NSLOT-1:0] take,
   output logic [CNTW-1:0]  cnt
);
   assign take[0] = !blocked[0];

   genvar j;
   generate
      for (j = 1; j < NSLOT; j++) begin : g_link
         assign take[j] = take[j-1] && !ends_run[j-1] && !blocked[j];
      end
   endgenerate

   always_comb begin
      cnt = '0;
      for (int k = 0; k < NSLOT; k++)
         if (take[k]) cnt = cnt + CNTW'(1);
   end

   always_comb begin
      for (int k = 1; k < NSLOT; k++) begin
         assert_contig_R6: assert (!take[k] || take[k-1]);
         assert_taken_R5:  assert (!(take[k] && ends_run[k-1]));
      end
   end
endmodule

// File: rtl/dsteer_out.sv
module dsteer_out #(
   parameter int NSLOT = 4,
   parameter int SEQW  = 4,
   localparam int CNTW = $clog2(NSLOT + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ready,
   input  logic [NSLOT-1:0]      take,
   input  logic [CNTW-1:0]       cnt,
   output logic [NSLOT-1:0]      slot_valid,
   output logic [NSLOT*SEQW-1:0] slot_seq
);
   logic [SEQW-1:0] base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base       <= '0;
         slot_valid <= '0;
         slot_seq   <= '0;
      end else if (ready) begin
         base       <= base + SEQW'(cnt);
         slot_valid <= take;
         for (int k = 0; k < NSLOT; k++)
            slot_seq[k*SEQW +: SEQW] <= base + SEQW'(k);
      end
   end

   assert_prefix_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((slot_valid + NSLOT'(1)) & slot_valid) == '0);
   assert_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> $countones(slot_valid) == int'($past(cnt)));
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |=> $stable(slot_valid) && $stable(slot_seq));
endmodule

// File: rtl/dsteer_top.sv
module dsteer_top #(
   parameter int NSLOT      = 4,
   parameter int UOPW       = 3,
   parameter int WINW       = 4,
   parameter int SEQW       = 4,
   parameter int SIMPLE_MAX = 2,
   localparam int CNTW      = $clog2(NSLOT + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NSLOT-1:0]      in_valid,
   input  logic [NSLOT*UOPW-1:0] in_uops,
   input  logic [NSLOT*WINW-1:0] in_win,
   input  logic [NSLOT-1:0]      in_taken,
   input  logic                  out_ready,
   output logic [CNTW-1:0]       consume_cnt,
   output logic [NSLOT-1:0]      slot_valid,
   output logic [NSLOT*SEQW-1:0] slot_seq
);
   if (NSLOT < 2) begin : g_bad_nslot
      $error("NSLOT must be at least 2");
   end
   if (SIMPLE_MAX >= (1 << UOPW)) begin : g_bad_simple
      $error("SIMPLE_MAX must fit in UOPW bits");
   end
   if (SEQW < CNTW) begin : g_bad_seq
      $error("SEQW must cover a full group");
   end

   logic [NSLOT-1:0] blocked, ends_run, take;
   logic [CNTW-1:0]  run_cnt;

   genvar j;
   generate
      for (j = 0; j < NSLOT; j++) begin : g_entry
         dsteer_class #(
            .UOPW(UOPW), .WINW(WINW), .SIMPLE_MAX(SIMPLE_MAX),
            .IS_HEAD(j == 0)
         ) u_class (
            .valid    (in_valid[j]),
            .uops     (in_uops[j*UOPW +: UOPW]),
            .win      (in_win[j*WINW +: WINW]),
            .head_win (in_win[0 +: WINW]),
            .taken    (in_taken[j]),
            .blocked  (blocked[j]),
            .ends_run (ends_run[j])
         );
      end
   endgenerate

   dsteer_chain #(.NSLOT(NSLOT)) u_chain (
      .blocked (blocked),
      .ends_run(ends_run),
      .take    (take),
      .cnt     (run_cnt)
   );

   assign consume_cnt = out_ready ? run_cnt : '0;

   dsteer_out #(.NSLOT(NSLOT), .SEQW(SEQW)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .ready     (out_ready),
      .take      (take),
      .cnt       (run_cnt),
      .slot_valid(slot_valid),
      .slot_seq  (slot_seq)
   );

   assert_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ready && in_valid[0]) |-> consume_cnt != '0);
   assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ready |-> consume_cnt == '0);
   always_comb begin
      for (int k = 1; k < NSLOT; k++) begin
         assert_complex_R3: assert (!take[k] ||
            in_uops[k*UOPW +: UOPW] <= UOPW'(SIMPLE_MAX));
         assert_window_R4: assert (!take[k] ||
            in_win[k*WINW +: WINW] == in_win[0 +: WINW]);
      end
   end
endmodule

// File: tb/dsteer_top_bench.sv
module dsteer_top_bench;
   localparam int N = 4, UW = 3, WW = 4, SW = 4;

   logic clk = 1'b0, rst_n = 1'b0, ready = 1'b0;
   logic [N-1:0] v = '0, tk = '0;
   logic [N*UW-1:0] uops = '0;
   logic [N*WW-1:0] win = '0;
   logic [2:0] cnt;
   logic [N-1:0] sv;
   logic [N*SW-1:0] sseq;
   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   dsteer_top u_dsteer_top (
      .clk(clk), .rst_n(rst_n), .in_valid(v), .in_uops(uops), .in_win(win),
      .in_taken(tk), .out_ready(ready), .consume_cnt(cnt),
      .slot_valid(sv), .slot_seq(sseq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int base = 0;
      @(negedge clk);
      chk(sv == 0, "R1 reset valid", sv, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sv == 0, "R1 idle valid", sv, 0);
      for (int c = 0; c < 65536; c++) begin
         int len;
         string tag;
         logic [N-1:0] pv;
         logic [N*SW-1:0] ps;
         for (int j = 0; j < N; j++) begin
            v[j]  = c[4*j+3];
            uops[j*UW +: UW] = c[4*j+2] ? 3'd3 : (j == 0 ? 3'd1 : 3'd2);
            win[j*WW +: WW]  = c[4*j+1] ? 4'd9 : 4'd3;
            tk[j] = c[4*j];
         end
         len = 0; tag = "R2";
         for (int j = 0; j < N; j++) begin
            if (!v[j]) begin tag = "R6"; break; end
            if (j > 0 && uops[j*UW +: UW] > 3'd2) begin tag = "R3"; break; end
            if (j > 0 && win[j*WW +: WW] != win[0 +: WW]) begin tag = "R4"; break; end
            len++;
            if (tk[j]) begin tag = "R5"; break; end
         end
         if (c % 8 == 0) begin
            pv = sv; ps = sseq;
            ready = 1'b0;
            #1 chk(cnt == 0, "R7 stall count", cnt, 0);
            @(negedge clk);
            chk(sv == pv, "R7 hold valid", sv, pv);
            chk(sseq == ps, "R7 hold seq", sseq, ps);
         end
         ready = 1'b1;
         #1 chk(cnt == len, tag, cnt, len);
         @(negedge clk);
         chk(sv == N'((1 << len) - 1), "R8 slot mask", sv, (1 << len) - 1);
         for (int j = 0; j < len; j++)
            chk(sseq[j*SW +: SW] == SW'(base + j), "R9 sequence",
                sseq[j*SW +: SW], (base + j) % 16);
         base = (base + len) % 16;
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule